// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Checker

This block watches the command pins of a four-bank synchronous DRAM. On every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable levels into a command. It follows each bank through four states: idle, row open, reading and writing. For every open bank it holds the row address that opened it. A command that the target bank's present state does not allow raises a one-cycle illegal flag and leaves every bank state as it was.

A controller model or a protocol monitor can place it beside a memory interface. Address bit 10 has two meanings that the block resolves. With a read or write it requests automatic close at the end of the burst. With a precharge it closes every bank. Data movement, refresh counting and timing gaps are outside this block. A burst-done input tells it when the current burst has finished.

Top module: `sdram_cmd_checker`

## Requirements
- R1: While cs_n is high, no strobe combination changes any bank state or raises illegal_o.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as 111 NOP, 110 burst stop, 101 READ, 100 WRITE, 011 ACTIVATE, 010 PRECHARGE, 001 auto-refresh and 000 mode set.
- R3: ACTIVATE to an idle bank moves it to row open and stores addr in that bank's row field. Bank b's state is bank_state_o[2b+1:2b], coded 0 idle, 1 row open, 2 reading and 3 writing. Its row is row_o[12b+11:12b].
- R4: ACTIVATE to a bank that is not idle is illegal.
- R5: READ, WRITE or burst stop aimed at an idle bank is illegal.
- R6: READ or WRITE to a non-idle bank moves it to reading or writing. Any other bank that is reading or writing leaves that state as if its burst had ended.
- R7: When burst_done is high, a reading or writing bank returns to row open. It goes to idle with its row cleared instead if addr[10] was high on the command that started the burst.
- R8: PRECHARGE with addr[10] low closes the addressed bank to idle with its row cleared, from any state. On an idle bank it is a legal no-op.
- R9: PRECHARGE with addr[10] high closes all banks to idle and clears every row.
- R10: Auto-refresh and mode set are legal and change nothing when all banks are idle. They are illegal when any bank is not idle.
- R11: Burst stop on a row-open bank is a no-op. On a reading or writing bank it returns the bank to row open.
- R12: illegal_o is high for exactly the cycle after the edge that sampled an illegal command, and that command changes no bank state.
- R13: While rst_n is low, every bank is idle, every row is zero and illegal_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address; bit 10 also selects close behaviour |
| burst_done | input | 1 | The current burst has finished |
| bank_state_o | output | 8 | Two-bit state per bank |
| row_o | output | 48 | Stored row per bank |
| illegal_o | output | 1 | One-cycle illegal-command flag |

## Verification
The assertions assume that burst_done is raised only while some bank is reading or writing. They also assume that every command input is steady around the sampling edge. The bench changes inputs on the falling edge and raises burst_done only after it has started a burst. Its reference model follows the pins alone, so a burst_done that went against this assumption would be caught as a mismatch and not pass unnoticed.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int NBANK = 4,
  parameter int ROWW  = 12,
  parameter int APBIT = 10,
  parameter int BAW   = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BAW-1:0]          ba,
  input  logic [ROWW-1:0]         addr,
  input  logic                    burst_done,
  output logic [2*NBANK-1:0]      bank_state_o,
  output logic [ROWW*NBANK-1:0]   row_o,
  output logic                    illegal_o
);
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_RD = 2'd2, S_WR = 2'd3;

  logic [1:0]      st  [NBANK];
  logic [ROWW-1:0] row [NBANK];
  logic            ap  [NBANK];

  wire [2:0] op     = {ras_n, cas_n, we_n};
  wire       sel    = !cs_n;
  wire       is_bst = sel && op == 3'b110;
  wire       is_rd  = sel && op == 3'b101;
  wire       is_wr  = sel && op == 3'b100;
  wire       is_act = sel && op == 3'b011;
  wire       is_pre = sel && op == 3'b010;
  wire       is_ref = sel && op == 3'b001;
  wire       is_mrs = sel && op == 3'b000;
  wire       a10    = addr[APBIT];
  wire [1:0] tgt    = st[ba];

  logic any_open;
  always_comb begin
    any_open = 1'b0;
    for (int b = 0; b < NBANK; b++) any_open = any_open | (st[b] != S_IDLE);
  end

  wire bad = (is_act && tgt != S_IDLE)
          || ((is_rd || is_wr || is_bst) && tgt == S_IDLE)
          || ((is_ref || is_mrs) && any_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_o <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        st[b]  <= S_IDLE;
        row[b] <= '0;
        ap[b]  <= 1'b0;
      end
    end else begin
      illegal_o <= bad;
      for (int b = 0; b < NBANK; b++) begin
        if (burst_done && st[b][1]) begin
          ap[b] <= 1'b0;
          if (ap[b]) begin
            st[b]  <= S_IDLE;
            row[b] <= '0;
          end else st[b] <= S_OPEN;
        end
        if (!bad) begin
          if (is_pre && (a10 || ba == BAW'(b))) begin
            st[b]  <= S_IDLE;
            row[b] <= '0;
            ap[b]  <= 1'b0;
          end else if ((is_rd || is_wr) && ba != BAW'(b) && st[b][1]) begin
            ap[b] <= 1'b0;
            if (ap[b]) begin
              st[b]  <= S_IDLE;
              row[b] <= '0;
            end else st[b] <= S_OPEN;
          end else if (ba == BAW'(b)) begin
            if (is_act) begin
              st[b]  <= S_OPEN;
              row[b] <= addr;
            end else if (is_rd || is_wr) begin
              st[b] <= is_rd ? S_RD : S_WR;
              ap[b] <= a10;
            end else if (is_bst && st[b][1]) begin
              st[b] <= S_OPEN;
              ap[b] <= 1'b0;
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_out
    assign bank_state_o[2*g +: 2]  = st[g];
    assign row_o[ROWW*g +: ROWW]   = row[g];
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cs_n) && !$past(burst_done) |-> !illegal_o && bank_state_o == $past(bank_state_o)); // R1
  AST_ACT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_act) && $past(tgt) == S_IDLE |-> st[$past(ba)] == S_OPEN && row[$past(ba)] == $past(addr)); // R3
  AST_PREA_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_pre) && $past(a10) |-> bank_state_o == '0 && row_o == '0); // R9
  AST_REF_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_ref || is_mrs) && $past(bank_state_o) != '0 |-> illegal_o); // R10
  AST_ILLEGAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && illegal_o && !$past(burst_done) |-> bank_state_o == $past(bank_state_o) && row_o == $past(row_o)); // R12
endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;
  logic clk = 0, rst_n = 0, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, burst_done = 0;
  logic [1:0] ba = 0;
  logic [11:0] addr = 0;
  logic [7:0] bank_state_o;
  logic [47:0] row_o;
  logic illegal_o;

  sdram_cmd_checker dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .burst_done(burst_done),
    .bank_state_o(bank_state_o), .row_o(row_o), .illegal_o(illegal_o));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int mst[4], mrow[4], map[4];
  bit mill;

  localparam bit [2:0] NOP = 3'b111, BST = 3'b110, RD = 3'b101, WR = 3'b100,
                       ACT = 3'b011, PRE = 3'b010, REF = 3'b001, MRS = 3'b000;

  task automatic compare(string tag);
    for (int b = 0; b < 4; b++) begin
      checks++;
      if (bank_state_o[2*b +: 2] != mst[b]) begin
        errors++;
        $display("FAIL %s bank%0d state actual=%0d expected=%0d", tag, b, bank_state_o[2*b +: 2], mst[b]);
      end
      checks++;
      if (row_o[12*b +: 12] != mrow[b]) begin
        errors++;
        $display("FAIL %s bank%0d row actual=%h expected=%h", tag, b, row_o[12*b +: 12], mrow[b]);
      end
    end
    checks++;
    if (illegal_o != mill) begin
      errors++;
      $display("FAIL %s illegal actual=%0d expected=%0d", tag, illegal_o, mill);
    end
  endtask

  function automatic void end_burst(int b);
    if (map[b] != 0) begin mst[b] = 0; mrow[b] = 0; end
    else mst[b] = 1;
    map[b] = 0;
  endfunction

  task automatic step(string tag, bit cs, bit [2:0] op, int b, int ad, bit bd);
    bit any_open = 0, bad = 0;
    int old[4];
    cs_n = cs; {ras_n, cas_n, we_n} = op; ba = 2'(b); addr = 12'(ad); burst_done = bd;
    for (int i = 0; i < 4; i++) begin old[i] = mst[i]; if (mst[i] != 0) any_open = 1; end
    if (!cs) begin
      if (op == ACT && old[b] != 0) bad = 1;
      if ((op == RD || op == WR || op == BST) && old[b] == 0) bad = 1;
      if ((op == REF || op == MRS) && any_open) bad = 1;
    end
    mill = bad;
    if (bd) for (int i = 0; i < 4; i++) if (old[i] >= 2) end_burst(i);
    if (!cs && !bad) begin
      case (op)
        ACT: begin mst[b] = 1; mrow[b] = ad; end
        RD, WR: begin
          for (int i = 0; i < 4; i++) if (i != b && old[i] >= 2) end_burst(i);
          mst[b] = (op == RD) ? 2 : 3; map[b] = (ad >> 10) & 1;
        end
        BST: if (old[b] >= 2) begin mst[b] = 1; map[b] = 0; end
        PRE: for (int i = 0; i < 4; i++)
               if (((ad >> 10) & 1) != 0 || i == b) begin mst[i] = 0; mrow[i] = 0; map[i] = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mrow[i] = 0; map[i] = 0; end
    mill = 0;
    repeat (3) @(negedge clk);
    compare("R13 reset");
    rst_n = 1;
    step("R1 deselect act", 1, ACT, 0, 12'h111, 0);
    step("R1 deselect read", 1, RD, 1, 0, 0);
    step("R2 nop", 0, NOP, 0, 0, 0);
    step("R3 act bank0", 0, ACT, 0, 12'h5A5, 0);
    step("R3 act bank2", 0, ACT, 2, 12'hFFF, 0);
    step("R4 reopen bank0", 0, ACT, 0, 12'h001, 0);
    step("R12 pulse drops", 0, NOP, 0, 0, 0);
    step("R5 read idle", 0, RD, 1, 0, 0);
    step("R5 write idle", 0, WR, 3, 0, 0);
    step("R5 bst idle", 0, BST, 1, 0, 0);
    step("R10 refresh open", 0, REF, 0, 0, 0);
    step("R10 modeset open", 0, MRS, 0, 0, 0);
    step("R11 bst open", 0, BST, 0, 0, 0);
    step("R6 read bank0", 0, RD, 0, 0, 0);
    step("R6 write bank2 ap", 0, WR, 2, 12'h400, 0);
    step("R7 done ap to idle", 0, NOP, 0, 0, 1);
    step("R6 read bank0 ap", 0, RD, 0, 12'h400, 0);
    step("R7 done read ap", 0, NOP, 0, 0, 1);
    step("R3 act bank0 again", 0, ACT, 0, 12'h123, 0);
    step("R6 write bank0", 0, WR, 0, 0, 0);
    step("R7 done to open", 0, NOP, 0, 0, 1);
    step("R6 read bank0", 0, RD, 0, 0, 0);
    step("R11 bst read", 0, BST, 0, 0, 0);
    step("R8 precharge bank0", 0, PRE, 0, 0, 0);
    step("R8 precharge idle", 0, PRE, 1, 0, 0);
    step("R3 act bank1", 0, ACT, 1, 12'hABC, 0);
    step("R3 act bank3", 0, ACT, 3, 12'h3C3, 0);
    step("R8 read bank3", 0, RD, 3, 0, 0);
    step("R8 precharge reading", 0, PRE, 3, 0, 0);
    step("R6 write bank1", 0, WR, 1, 0, 0);
    step("R9 precharge all", 0, PRE, 2, 12'h400, 0);
    step("R10 refresh idle", 0, REF, 0, 0, 0);
    step("R10 modeset idle", 0, MRS, 0, 12'h030, 0);
    step("R1 deselect bst", 1, BST, 0, 0, 0);
    step("R2 final nop", 0, NOP, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule